// File: doc/BRIEF.md
# DMA-to-SCSI Acknowledge and Memory Select Glue

This block sits between an 8-bit processor with an on-chip DMA channel and a SCSI interface chip that paces data with a request/acknowledge handshake. The DMA channel has no acknowledge output. The block reads the processor's two cycle-status lines to sort each bus cycle into a DMA cycle or an ordinary CPU cycle. It then builds the acknowledge and the SCSI-side read or write strobe itself, and it decodes the memory chip selects for the board.

A DMA byte moves as a pair of cycles: a read and then a write. For buffer-to-SCSI transfers, the acknowledge and the SCSI write strobe come during the read half, while the buffer RAM drives the data. The write half goes to no device at all, which gives the SCSI chip time to drop its request and raise it again for the next byte. For SCSI-to-buffer transfers, the acknowledge and the SCSI read strobe come during the read half with no memory selected. The write half then selects the buffer RAM, which stores the byte. Every access to the program ROM gets a single wait state. All inputs are registered once, decoded, and registered again, so every output follows its inputs by two clocks.

Top module: `dglue_top`

## Requirements
- R1: While reset is high and on the first clock after it, every output is low.
- R2: A cycle is DMA when `cyc_stat_i`=1 and `fetch_late_i`=0. Any other combination, including programmed I/O reads of the SCSI chip, is a CPU cycle and never raises `dma_ack_o`, `scsi_rd_o` or `scsi_wr_o`.
- R3: With `xfer_dir_i`=0 (memory to SCSI), an armed DMA read raises `dma_ack_o` and `scsi_wr_o` and keeps the addressed memory select active.
- R4: With `xfer_dir_i`=0, a DMA write asserts no chip select, no acknowledge and no strobe.
- R5: With `xfer_dir_i`=1 (SCSI to memory), an armed DMA read raises `dma_ack_o` and `scsi_rd_o` with no memory select. A DMA write selects the addressed memory with no acknowledge.
- R6: `dreq_i` is sampled only on the first clock of a cycle (the clock where `mreq_i` is first seen high). If it was low there, the cycle gets no acknowledge even if it rises later. If it was high there, the acknowledge lasts the whole cycle even if it falls.
- R7: Decode while `mreq_i`=1. With `pbuf_en_i`=1, select `pbuf_cs_o[bank_i]`. Otherwise `a15_i`=0 selects `rom_cs_o` and `a15_i`=1 selects `dram_cs_o`. At most one select is ever high.
- R8: `wait_o` is high for exactly one clock at the start of each ROM access that is not suppressed, and never on RAM accesses.
- R9: Outputs change two rising edges after their inputs, and they return low two edges after `mreq_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst | input | 1 | synchronous active-high reset |
| fetch_late_i | input | 1 | delayed opcode-fetch status, 1 = fetch |
| cyc_stat_i | input | 1 | cycle status line |
| mreq_i | input | 1 | memory request, active high |
| rd_i | input | 1 | read cycle, active high |
| wr_i | input | 1 | write cycle, active high |
| a15_i | input | 1 | top address bit |
| pbuf_en_i | input | 1 | packet buffer window enable |
| bank_i | input | BANK_W | packet buffer bank number |
| dreq_i | input | 1 | data request from the SCSI chip |
| xfer_dir_i | input | 1 | 0 = memory to SCSI, 1 = SCSI to memory |
| dma_ack_o | output | 1 | DMA acknowledge to the SCSI chip |
| scsi_rd_o | output | 1 | SCSI chip read strobe |
| scsi_wr_o | output | 1 | SCSI chip write strobe |
| rom_cs_o | output | 1 | program ROM select |
| dram_cs_o | output | 1 | data RAM select |
| pbuf_cs_o | output | NBUF | packet buffer RAM selects |
| wait_o | output | 1 | wait request to the processor |

## Verification
The bench sweeps every combination of direction, the four status-line codes, read versus write, the four memory regions and the request level at cycle start. This separates DMA from CPU classification, the suppressed half of each pair from the live half, and region decode from suppression. A second set holds the request at one level on the first clock and flips it on the second, which tells start-of-cycle sampling apart from level following. Each cycle is checked on its first and second output clocks, which shows a one-clock wait and a held acknowledge, and again after the request falls, which shows the release timing.

// File: rtl/dglue_pkg.sv
package dglue_pkg;
  typedef enum logic [1:0] {
    RGN_ROM  = 2'd0,
    RGN_DRAM = 2'd1,
    RGN_PBUF = 2'd2
  } region_e;

  localparam int CS_ROM  = 0;
  localparam int CS_DRAM = 1;
  localparam int CS_PBUF = 2;
endpackage

// File: rtl/dglue_sampler.sv
module dglue_sampler #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_late_i,
  input  logic              cyc_stat_i,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              a15_i,
  input  logic              pbuf_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              dreq_i,
  output logic              mreq_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              a15_q,
  output logic              pbuf_en_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              dreq_q,
  output logic              dma_q,
  output logic              start_o
);
  logic mreq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_q    <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      a15_q     <= 1'b0;
      pbuf_en_q <= 1'b0;
      bank_q    <= '0;
      dreq_q    <= 1'b0;
      dma_q     <= 1'b0;
      mreq_d    <= 1'b0;
    end else begin
      mreq_q    <= mreq_i;
      rd_q      <= rd_i;
      wr_q      <= wr_i;
      a15_q     <= a15_i;
      pbuf_en_q <= pbuf_en_i;
      bank_q    <= bank_i;
      dreq_q    <= dreq_i;
      dma_q     <= cyc_stat_i & ~fetch_late_i;
      mreq_d    <= mreq_q;
    end
  end

  assign start_o = mreq_q & ~mreq_d;

  AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R6
endmodule

// File: rtl/dglue_decode.sv
module dglue_decode
  import dglue_pkg::*;
#(
  parameter int NBUF   = 2,
  parameter int BANK_W = 1,
  parameter int NCS    = CS_PBUF + NBUF
) (
  input  logic              mreq_q,
  input  logic              a15_q,
  input  logic              pbuf_en_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic              suppress_i,
  output logic [NCS-1:0]    cs_raw_o,
  output logic              rom_hit_o
);
  region_e rgn;

  always_comb begin
    if (pbuf_en_q)  rgn = RGN_PBUF;
    else if (a15_q) rgn = RGN_DRAM;
    else            rgn = RGN_ROM;
  end

  logic live;
  assign live      = mreq_q & ~suppress_i;
  assign rom_hit_o = live & (rgn == RGN_ROM);

  assign cs_raw_o[CS_ROM]  = rom_hit_o;
  assign cs_raw_o[CS_DRAM] = live & (rgn == RGN_DRAM);

  for (genvar k = 0; k < NBUF; k++) begin : g_pbuf
    assign cs_raw_o[CS_PBUF+k] = live & (rgn == RGN_PBUF) &
                                 (bank_q == BANK_W'(k));
  end
endmodule

// File: rtl/dglue_strobe.sv
module dglue_strobe (
  input  logic clk,
  input  logic rst,
  input  logic mreq_q,
  input  logic rd_q,
  input  logic wr_q,
  input  logic dma_q,
  input  logic dreq_q,
  input  logic start_i,
  input  logic xfer_dir_i,
  output logic suppress_o,
  output logic dma_ack_o,
  output logic scsi_rd_o,
  output logic scsi_wr_o
);
  logic armed_r, armed_now, ack_n;

  assign armed_now  = start_i ? dreq_q : armed_r;
  assign ack_n      = mreq_q & rd_q & dma_q & armed_now;
  assign suppress_o = mreq_q & dma_q &
                      ((wr_q & ~xfer_dir_i) | (rd_q & xfer_dir_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_r   <= 1'b0;
      dma_ack_o <= 1'b0;
      scsi_rd_o <= 1'b0;
      scsi_wr_o <= 1'b0;
    end else begin
      armed_r   <= mreq_q & armed_now;
      dma_ack_o <= ack_n;
      scsi_rd_o <= ack_n & xfer_dir_i;
      scsi_wr_o <= ack_n & ~xfer_dir_i;
    end
  end

  AST_ACK_ONLY_DMA_READ: assert property (@(posedge clk) disable iff (rst)
    dma_ack_o |-> $past(dma_q && rd_q && mreq_q)); // R2
  AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    (scsi_rd_o || scsi_wr_o) |-> dma_ack_o); // R3
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(scsi_rd_o && scsi_wr_o)); // R5
  AST_ACK_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    ($rose(dma_ack_o)) |-> $past(dreq_q)); // R6
endmodule

// File: rtl/dglue_wait.sv
module dglue_wait (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rom_hit_i,
  output logic wait_o
);
  always_ff @(posedge clk) begin
    if (rst) wait_o <= 1'b0;
    else     wait_o <= start_i & rom_hit_i;
  end

  AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wait_o |=> !wait_o); // R8
endmodule

// File: rtl/dglue_top.sv
module dglue_top
  import dglue_pkg::*;
#(
  parameter int NBUF   = 2,
  parameter int BANK_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_late_i,
  input  logic              cyc_stat_i,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              a15_i,
  input  logic              pbuf_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              dreq_i,
  input  logic              xfer_dir_i,
  output logic              dma_ack_o,
  output logic              scsi_rd_o,
  output logic              scsi_wr_o,
  output logic              rom_cs_o,
  output logic              dram_cs_o,
  output logic [NBUF-1:0]   pbuf_cs_o,
  output logic              wait_o
);
  localparam int NCS = CS_PBUF + NBUF;

  logic              mreq_q, rd_q, wr_q, a15_q, pbuf_en_q, dreq_q, dma_q, start;
  logic [BANK_W-1:0] bank_q;
  logic              suppress, rom_hit;
  logic [NCS-1:0]    cs_raw, cs_q;

  dglue_sampler #(.BANK_W(BANK_W)) u_samp (
    .clk(clk), .rst(rst),
    .fetch_late_i(fetch_late_i), .cyc_stat_i(cyc_stat_i),
    .mreq_i(mreq_i), .rd_i(rd_i), .wr_i(wr_i), .a15_i(a15_i),
    .pbuf_en_i(pbuf_en_i), .bank_i(bank_i), .dreq_i(dreq_i),
    .mreq_q(mreq_q), .rd_q(rd_q), .wr_q(wr_q), .a15_q(a15_q),
    .pbuf_en_q(pbuf_en_q), .bank_q(bank_q), .dreq_q(dreq_q),
    .dma_q(dma_q), .start_o(start)
  );

  dglue_strobe u_strb (
    .clk(clk), .rst(rst),
    .mreq_q(mreq_q), .rd_q(rd_q), .wr_q(wr_q), .dma_q(dma_q),
    .dreq_q(dreq_q), .start_i(start), .xfer_dir_i(xfer_dir_i),
    .suppress_o(suppress), .dma_ack_o(dma_ack_o),
    .scsi_rd_o(scsi_rd_o), .scsi_wr_o(scsi_wr_o)
  );

  dglue_decode #(.NBUF(NBUF), .BANK_W(BANK_W), .NCS(NCS)) u_dec (
    .mreq_q(mreq_q), .a15_q(a15_q), .pbuf_en_q(pbuf_en_q), .bank_q(bank_q),
    .suppress_i(suppress), .cs_raw_o(cs_raw), .rom_hit_o(rom_hit)
  );

  dglue_wait u_wait (
    .clk(clk), .rst(rst), .start_i(start), .rom_hit_i(rom_hit),
    .wait_o(wait_o)
  );

  always_ff @(posedge clk) begin
    if (rst) cs_q <= '0;
    else     cs_q <= cs_raw;
  end

  assign rom_cs_o  = cs_q[CS_ROM];
  assign dram_cs_o = cs_q[CS_DRAM];
  for (genvar k = 0; k < NBUF; k++) begin : g_pbuf_out
    assign pbuf_cs_o[k] = cs_q[CS_PBUF+k];
  end

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_q)); // R7
  AST_WAIT_ON_ROM: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> rom_cs_o); // R8
  AST_SCSI_RD_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    scsi_rd_o |-> (cs_q == '0)); // R5
endmodule

// File: tb/dglue_top_tb_top.sv
module dglue_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_late_i = 0, cyc_stat_i = 0, mreq_i = 0, rd_i = 0, wr_i = 0;
  logic a15_i = 0, pbuf_en_i = 0, dreq_i = 0, xfer_dir_i = 0;
  logic [0:0] bank_i = '0;
  logic dma_ack_o, scsi_rd_o, scsi_wr_o, rom_cs_o, dram_cs_o, wait_o;
  logic [NBUF-1:0] pbuf_cs_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dglue_top #(.NBUF(NBUF)) dut_i (
    .clk(clk), .rst(rst), .fetch_late_i(fetch_late_i), .cyc_stat_i(cyc_stat_i),
    .mreq_i(mreq_i), .rd_i(rd_i), .wr_i(wr_i), .a15_i(a15_i),
    .pbuf_en_i(pbuf_en_i), .bank_i(bank_i), .dreq_i(dreq_i),
    .xfer_dir_i(xfer_dir_i), .dma_ack_o(dma_ack_o), .scsi_rd_o(scsi_rd_o),
    .scsi_wr_o(scsi_wr_o), .rom_cs_o(rom_cs_o), .dram_cs_o(dram_cs_o),
    .pbuf_cs_o(pbuf_cs_o), .wait_o(wait_o)
  );

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] strobes();
    return {scsi_wr_o, scsi_rd_o, dma_ack_o};
  endfunction
  function automatic logic [3:0] selects();
    return {pbuf_cs_o, dram_cs_o, rom_cs_o};
  endfunction

  // One bus cycle of three clocks with mreq high; region 0 rom, 1 dram, 2/3 pbuf bank 0/1
  task automatic bus_cycle(input bit dir, input bit fetch, input bit st, input bit rd,
                           input int rg, input bit dq_start, input bit dq_late);
    bit dma, sup, ack;
    logic [3:0] cs_e;
    logic [2:0] stb_e;
    dma = st & ~fetch;
    sup = dma & ((~rd & ~dir) | (rd & dir));
    ack = dma & rd & dq_start;
    stb_e = {ack & ~dir, ack & dir, ack};
    cs_e = sup ? 4'b0 : (4'b1 << rg);
    @(negedge clk);
    xfer_dir_i = dir; fetch_late_i = fetch; cyc_stat_i = st;
    rd_i = rd; wr_i = ~rd; mreq_i = 1'b1;
    a15_i = (rg == 1); pbuf_en_i = (rg >= 2); bank_i = 1'(rg == 3);
    dreq_i = dq_start;
    @(negedge clk);
    dreq_i = dq_late;
    @(negedge clk);
    cmp("R2 R3 R5 R6 strobes first", {5'b0, strobes()}, {5'b0, stb_e});
    cmp("R4 R5 R7 selects first", {4'b0, selects()}, {4'b0, cs_e});
    cmp("R8 wait first", {7'b0, wait_o}, {7'b0, (rg == 0) & ~sup});
    @(negedge clk);
    cmp("R6 strobes held", {5'b0, strobes()}, {5'b0, stb_e});
    cmp("R7 selects held", {4'b0, selects()}, {4'b0, cs_e});
    cmp("R8 wait one clock", {7'b0, wait_o}, 8'b0);
    mreq_i = 0; rd_i = 0; wr_i = 0; dreq_i = 0;
    @(negedge clk);
    @(negedge clk);
    cmp("R9 release", {wait_o, selects(), strobes()}, 8'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset", {wait_o, selects(), strobes()}, 8'b0);
    rst = 0;
    @(negedge clk);
    cmp("R1 after reset", {wait_o, selects(), strobes()}, 8'b0);
    for (int d = 0; d < 2; d++)
      for (int fs = 0; fs < 4; fs++)
        for (int op = 0; op < 2; op++)
          for (int rg = 0; rg < 4; rg++)
            for (int dq = 0; dq < 2; dq++)
              bus_cycle(d[0], fs[1], fs[0], op[0], rg, dq[0], dq[0]);
    // R6: request sampled at cycle start only
    for (int d = 0; d < 2; d++)
      for (int rg = 0; rg < 4; rg++) begin
        bus_cycle(d[0], 1'b0, 1'b1, 1'b1, rg, 1'b0, 1'b1);
        bus_cycle(d[0], 1'b0, 1'b1, 1'b1, rg, 1'b1, 1'b0);
      end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule